// File: doc/BRIEF.md
# Shared-Counter Multichannel PWM Timer

This block is a pulse-width modulation timer in which a single up-counter, one prescaler and one period value serve every output channel. Software controls it over a plain register bus: one write strobe, an address and write data, with combinational read data for the addressed register. A control register starts and stops the counter and selects a power-of-two clock divider. A period register sets the count at which the counter wraps. Each channel has its own compare value and its own mode/polarity field.

While the counter is stopped, period and compare writes take effect at once. While it runs, they go into a buffer and become active only at the next period start, which is the counter's wrap to zero. Reads always return the active value, so software can poll a register until a buffered write has landed. Polarity and enable changes are not buffered: a channel output follows them on the next clock.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset, the control register, every channel mode field and every compare value read 0, the period register reads 16'hFFFF, the count reads 0 and all outputs are low.
- R2: The address map is: 0 control, 1 period, 2 count (read only), 4+2n channel n mode, 5+2n channel n compare, and every other address reads 0. In the control register, bits [4:3] are the clock mode and bits [2:0] the divider exponent. Clock mode 00 holds the count and clears the divider. Any nonzero clock mode runs the counter.
- R3: While the counter runs with divider exponent p, the count advances once every 2^p clocks.
- R4: On an advance, the counter wraps to 0 if it has reached or passed the active period value. Otherwise it adds 1, so one period spans period+1 counts.
- R5: While stopped, a period write is visible on readback one clock later and is active from then on.
- R6: While running, a period write goes to a buffer. The active value, and its readback, change only on the advance that wraps the counter.
- R7: Compare writes follow the same rule: immediate while stopped, and loaded on the wrap while running.
- R8: In the channel mode field, bit 3 selects edge-aligned PWM and bits [1:0] are the edge/level code. With bit 3 set and code 10, the output is high while count < compare. The output register adds one clock.
- R9: With bit 3 set and code 01, the output is the inverse of the R8 level.
- R10: A mode field of 0, or any field without bit 3 set or with code 00 or 11, drives the output low.
- R11: With normal polarity, a compare of 0 keeps the output low and a compare above the period keeps it high for the whole period.
- R12: A change to a channel's mode field reaches its output one clock after the write edge, without waiting for a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data of the addressed register (combinational) |
| pwm_out | output | NCH | Channel outputs |

## Verification
A register write is sampled on a rising edge. Its readback, and the count, change right after that edge. A channel output is registered, so it shows the count, compare and mode from the previous cycle, one edge later. Buffered values become active on the same edge on which the counter wraps. The bench keeps a behavioural model that takes the same stimulus on the same rising edge. It compares every output and the addressed read data at the following falling edge, when all of these latencies have settled. Directed checks use the same rule and sample one falling edge after the edge that should cause the change.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int unsigned CTRL_ADDR = 0;
   localparam int unsigned MOD_ADDR  = 1;
   localparam int unsigned CNT_ADDR  = 2;
   localparam int unsigned CH_BASE   = 4;
   localparam int unsigned PS_W      = 3;

   typedef struct packed {
      logic [1:0]      clk_mode;
      logic [PS_W-1:0] ps;
   } tmr_ctrl_t;

   typedef struct packed {
      logic       msb;
      logic       msa;
      logic [1:0] els;
   } ch_ctl_t;

   typedef enum logic [1:0] {
      EL_OFF  = 2'b00,
      EL_INV  = 2'b01,
      EL_NORM = 2'b10,
      EL_RSVD = 2'b11
   } edge_lvl_e;

   function automatic int unsigned addr_bits(int unsigned nch);
      return $clog2(CH_BASE + 2 * nch);
   endfunction
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
   parameter int unsigned PSW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [PSW-1:0] ps,
   output logic           tick
);
   localparam int unsigned DW = (1 << PSW) - 1;

   logic [DW-1:0] div_q;
   logic [DW:0]   limit;

   always_comb begin
      limit = ({{DW{1'b0}}, 1'b1} << ps) - 1'b1;
      tick  = run && ({1'b0, div_q} >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (!run)   div_q <= '0;
      else if (tick)   div_q <= '0;
      else             div_q <= div_q + 1'b1;
   end

   // R2
   stop_clears_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> div_q == '0);
   // R3
   div_counts_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !tick |=> div_q == $past(div_q) + 1'b1);
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          mod_wr,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] mod_act,
   output logic          period_start
);
   logic [CW-1:0] cnt_q, mod_buf_q, mod_act_q;

   assign period_start = tick && (cnt_q >= mod_act_q);
   assign cnt          = cnt_q;
   assign mod_act      = mod_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (period_start) cnt_q <= '0;
      else if (tick)         cnt_q <= cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_buf_q <= '1;
         mod_act_q <= '1;
      end else begin
         if (mod_wr) mod_buf_q <= wdata;
         if (!run)              mod_act_q <= mod_wr ? wdata : mod_buf_q;
         else if (period_start) mod_act_q <= mod_buf_q;
      end
   end

   // R2
   count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !period_start |=> cnt_q == $past(cnt_q) + CW'(1));
   // R4
   count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> cnt_q == '0);
   // R5
   mod_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run && mod_wr |=> mod_act_q == $past(wdata));
   // R6
   mod_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !period_start |=> $stable(mod_act_q));
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
   import pwmt_pkg::*;
#(
   parameter int unsigned CW      = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          period_start,
   input  logic [CW-1:0] cnt,
   input  logic          ctl_wr,
   input  logic          cmp_wr,
   input  logic [CW-1:0] wdata,
   output ch_ctl_t       ctl,
   output logic [CW-1:0] cmp_act,
   output logic          pwm
);
   ch_ctl_t       ctl_q;
   logic [CW-1:0] cmp_buf_q, cmp_act_q;
   logic          below, lvl;

   assign ctl     = ctl_q;
   assign cmp_act = cmp_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= ch_ctl_t'(4'b0000);
         cmp_buf_q <= '0;
         cmp_act_q <= '0;
      end else begin
         if (ctl_wr) ctl_q     <= ch_ctl_t'(wdata[3:0]);
         if (cmp_wr) cmp_buf_q <= wdata;
         if (!run)              cmp_act_q <= cmp_wr ? wdata : cmp_buf_q;
         else if (period_start) cmp_act_q <= cmp_buf_q;
      end
   end

   always_comb begin
      below = cnt < cmp_act_q;
      lvl   = 1'b0;
      if (ctl_q.msb) begin
         case (edge_lvl_e'(ctl_q.els))
            EL_NORM: lvl = below;
            EL_INV:  lvl = !below;
            default: lvl = 1'b0;
         endcase
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= lvl;
         end
         assign pwm = pwm_q;

         // R10
         off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_q == ch_ctl_t'(4'b0000) |=> !pwm);
         // R11
         zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_q.msb && ctl_q.els == 2'b10 && cmp_act_q == '0 |=> !pwm);
      end else begin : g_out_comb
         assign pwm = lvl;
      end
   endgenerate

   // R7
   cmp_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !period_start |=> $stable(cmp_act_q));
endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
   import pwmt_pkg::*;
#(
   parameter int unsigned NCH     = 4,
   parameter int unsigned CW      = 16,
   parameter bit          OUT_REG = 1'b1,
   parameter int unsigned AW      = pwmt_pkg::addr_bits(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  bus_addr,
   input  logic           bus_wr,
   input  logic [CW-1:0]  bus_wdata,
   output logic [CW-1:0]  bus_rdata,
   output logic [NCH-1:0] pwm_out
);
   localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

   generate
      if (NCH < 1) begin : g_nch_bad
         $error("pwm_shared_timer: NCH must be at least 1");
      end
      if (CW < 8) begin : g_cw_bad
         $error("pwm_shared_timer: CW must be at least 8");
      end
      if (AW < pwmt_pkg::addr_bits(NCH)) begin : g_aw_bad
         $error("pwm_shared_timer: AW too small for channel count");
      end
   endgenerate

   tmr_ctrl_t              ctrl_q;
   logic                   run, tick, period_start;
   logic [CW-1:0]          cnt, mod_act;
   logic [NCH-1:0][CW-1:0] ch_cmp;
   ch_ctl_t [NCH-1:0]      ch_ctl;

   assign run = ctrl_q.clk_mode != 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= tmr_ctrl_t'('0);
      else if (bus_wr && bus_addr == AW'(CTRL_ADDR))
         ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
   end

   pwmt_prescaler #(.PSW(PS_W)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .ps   (ctrl_q.ps),
      .tick (tick)
   );

   pwmt_counter #(.CW(CW)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .tick        (tick),
      .mod_wr      (bus_wr && bus_addr == AW'(MOD_ADDR)),
      .wdata       (bus_wdata),
      .cnt         (cnt),
      .mod_act     (mod_act),
      .period_start(period_start)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         pwmt_channel #(.CW(CW), .OUT_REG(OUT_REG)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (run),
            .period_start(period_start),
            .cnt         (cnt),
            .ctl_wr      (bus_wr && bus_addr == AW'(CH_BASE + 2 * i)),
            .cmp_wr      (bus_wr && bus_addr == AW'(CH_BASE + 2 * i + 1)),
            .wdata       (bus_wdata),
            .ctl         (ch_ctl[i]),
            .cmp_act     (ch_cmp[i]),
            .pwm         (pwm_out[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(CTRL_ADDR)) bus_rdata[CTRL_W-1:0] = ctrl_q;
      if (bus_addr == AW'(MOD_ADDR))  bus_rdata = mod_act;
      if (bus_addr == AW'(CNT_ADDR))  bus_rdata = cnt;
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == AW'(CH_BASE + 2 * i))     bus_rdata = CW'(ch_ctl[i]);
         if (bus_addr == AW'(CH_BASE + 2 * i + 1)) bus_rdata = ch_cmp[i];
      end
   end

   // R2
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == AW'(CTRL_ADDR) |=> ctrl_q == $past(bus_wdata[CTRL_W-1:0]));
   // R4
   wrap_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |-> run);
endmodule

// File: tb/pwm_shared_timer_bench.sv
module pwm_shared_timer_bench;
   localparam int NCH = 4;
   localparam int CW  = 16;
   localparam int AW  = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  b_addr = AW'(2);
   logic           b_wr = 1'b0;
   logic [CW-1:0]  b_wdata = '0;
   logic [CW-1:0]  b_rdata;
   logic [NCH-1:0] pwm_out;

   always #4 clk = ~clk;

   pwm_shared_timer u_pwm_shared_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (b_addr),
      .bus_wr   (b_wr),
      .bus_wdata(b_wdata),
      .bus_rdata(b_rdata),
      .pwm_out  (pwm_out)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   string tag = "R1";

   // behavioural reference state
   int m_mode, m_ps, m_psc, m_cnt, m_mod_act, m_mod_buf;
   int m_cmp_act[NCH];
   int m_cmp_buf[NCH];
   int m_ctl[NCH];
   logic [NCH-1:0] m_out;

   function automatic logic lvl_of(int ctl, int cnt, int cmp);
      if (((ctl >> 3) & 1) == 0) return 1'b0;
      if ((ctl & 3) == 2) return (cnt < cmp);
      if ((ctl & 3) == 1) return !(cnt < cmp);
      return 1'b0;
   endfunction

   function automatic int model_read(int a);
      if (a == 0) return (m_mode << 3) | m_ps;
      if (a == 1) return m_mod_act;
      if (a == 2) return m_cnt;
      if (a >= 4 && a < 4 + 2 * NCH) begin
         if (a % 2 == 0) return m_ctl[(a - 4) / 2];
         return m_cmp_act[(a - 4) / 2];
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_ps = 0; m_psc = 0; m_cnt = 0;
         m_mod_act = 16'hFFFF; m_mod_buf = 16'hFFFF; m_out = '0;
         for (int i = 0; i < NCH; i++) begin
            m_cmp_act[i] = 0; m_cmp_buf[i] = 0; m_ctl[i] = 0;
         end
      end else begin
         bit run, tick, wrap;
         int a, d;
         a = int'(b_addr);
         d = int'(b_wdata);
         for (int i = 0; i < NCH; i++) m_out[i] = lvl_of(m_ctl[i], m_cnt, m_cmp_act[i]);
         run  = (m_mode != 0);
         tick = run && (m_psc >= (1 << m_ps) - 1);
         wrap = tick && (m_cnt >= m_mod_act);
         if (!run || tick) m_psc = 0; else m_psc = m_psc + 1;
         if (wrap) m_cnt = 0; else if (tick) m_cnt = m_cnt + 1;
         if (b_wr && a == 1) m_mod_buf = d;
         if (!run) m_mod_act = m_mod_buf; else if (wrap) m_mod_act = m_mod_buf;
         for (int i = 0; i < NCH; i++) begin
            if (b_wr && a == 4 + 2 * i) m_ctl[i] = d & 15;
            if (b_wr && a == 5 + 2 * i) m_cmp_buf[i] = d;
            if (!run) m_cmp_act[i] = m_cmp_buf[i];
            else if (wrap) m_cmp_act[i] = m_cmp_buf[i];
         end
         if (b_wr && a == 0) begin
            m_mode = (d >> 3) & 3;
            m_ps   = d & 7;
         end
      end
   end

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (pwm_out !== m_out) begin
            errors++;
            $display("FAIL %s pwm_out got %h exp %h (cycle %0d)", tag, pwm_out, m_out, cyc);
         end
         checks++;
         if (int'(b_rdata) != model_read(int'(b_addr))) begin
            errors++;
            $display("FAIL %s rdata@%0d got %h exp %h (cycle %0d)", tag, b_addr, b_rdata,
                     model_read(int'(b_addr)), cyc);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(posedge clk); #1;
      b_addr = AW'(a); b_wdata = CW'(d); b_wr = 1'b1;
      @(posedge clk); #1;
      b_wr = 1'b0; b_addr = AW'(2);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic rd_chk(input int a, input int exp, input string req);
      @(posedge clk); #1;
      b_addr = AW'(a);
      @(negedge clk);
      checks++;
      if (int'(b_rdata) != exp) begin
         errors++;
         $display("FAIL %s read@%0d got %h exp %h", req, a, b_rdata, exp);
      end
      @(posedge clk); #1;
      b_addr = AW'(2);
   endtask

   task automatic out_chk(input int ch, input logic exp, input string req);
      @(negedge clk);
      checks++;
      if (pwm_out[ch] !== exp) begin
         errors++;
         $display("FAIL %s pwm_out[%0d] got %b exp %b", req, ch, pwm_out[ch], exp);
      end
   endtask

   initial begin
      int hi2, hi3;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      tag = "R1";
      rd_chk(0, 0, "R1");
      rd_chk(1, 16'hFFFF, "R1");
      rd_chk(2, 0, "R1");
      for (int a = 4; a < 12; a++) rd_chk(a, 0, "R1");
      rd_chk(3, 0, "R2");
      @(negedge clk);
      checks++;
      if (pwm_out !== '0) begin
         errors++;
         $display("FAIL R1 pwm_out got %h exp 0", pwm_out);
      end

      // R5 stopped writes are immediate
      tag = "R5";
      wr(1, 9);
      rd_chk(1, 9, "R5");
      wr(5, 3); wr(7, 3); wr(9, 0); wr(11, 20);
      rd_chk(5, 3, "R7");
      tag = "R8";
      wr(4, 'hA); wr(6, 'h9); wr(8, 'hA); wr(10, 'hA);
      out_chk(0, 1'b1, "R8");
      out_chk(1, 1'b0, "R9");

      // R2 run with divide by one
      tag = "R2";
      wr(0, 'h08);
      rd_chk(0, 'h08, "R2");
      idle(30);

      // R6 buffered period write while running
      tag = "R6";
      wr(1, 5);
      tag = "R4";
      idle(25);
      rd_chk(1, 5, "R6");

      // R7 buffered compare write while running
      tag = "R7";
      wr(5, 7);
      idle(20);
      rd_chk(5, 7, "R7");

      // R11 duty extremes
      tag = "R11";
      hi2 = 0; hi3 = 0;
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         if (pwm_out[2]) hi2++;
         if (pwm_out[3]) hi3++;
      end
      checks++;
      if (hi2 != 0) begin
         errors++;
         $display("FAIL R11 zero-compare high cycles got %0d exp 0", hi2);
      end
      checks++;
      if (hi3 != 24) begin
         errors++;
         $display("FAIL R11 over-period high cycles got %0d exp 24", hi3);
      end

      // R12 polarity change mid-period
      tag = "R12";
      wr(6, 'hA);
      idle(12);
      wr(6, 'h9);
      idle(12);

      // R3 divide by four
      tag = "R3";
      wr(0, 'h0A);
      idle(60);

      // R10 disabled and reserved codes
      tag = "R10";
      wr(4, 0);
      wr(10, 'hB);
      wr(8, 'h2);
      idle(20);
      out_chk(0, 1'b0, "R10");
      out_chk(3, 1'b0, "R10");
      out_chk(2, 1'b0, "R10");

      // R2 stop holds the count; then R5 stopped write
      tag = "R2";
      wr(0, 'h02);
      idle(10);
      tag = "R5";
      wr(1, 3);
      rd_chk(1, 3, "R5");
      idle(4);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule